// File: doc/BRIEF.md
# Serial interrupt frame generator

This block is the peripheral end of a shared, open-drain serial interrupt wire that runs on the host bus clock. The register logic gives it a request level and a slot number. The block follows the frames on the wire: a start pulse, a train of three-clock data slots, and a stop pulse. In the slot that matches its number, it pulls the wire low for one clock and then drives it high for one clock. It releases the wire in every other clock. The host starts frames in continuous mode. In quiet mode the block may also start a frame itself when it has something to report. The width of each stop pulse selects the mode for the following frames.

The wire is modelled as a sampled input (`sirq_in`) and a pair of outputs (`sirq_oe`, `sirq_drv`) that drive a tristate pad outside the block. The pull-up resistor and the bus address decoding belong to other blocks.

A state machine tracks the frame. It has six states:
- `ST_IDLE`: wire released.
- `ST_KICK`: self-started pulse.
- `ST_START`: start pulse in progress.
- `ST_SLOTS`: slot train.
- `ST_WAIT_STOP`: idle gap after the slots.
- `ST_STOP`: stop pulse in progress.

Transitions:
- IDLE→START when the wire is seen low.
- IDLE→KICK in quiet mode with a request pending and the wire high.
- KICK→START always.
- START→SLOTS on the first clock the wire is high.
- SLOTS→WAIT_STOP after the turn-around clock of the last slot.
- WAIT_STOP→STOP when the wire is seen low.
- STOP→IDLE when the wire goes high again.

Top module: `sirq_frame_gen`

## Requirements
- R1: While reset is asserted and after it is released, the block is in continuous mode and does not drive the wire. With the wire idle and the request held high, it stays released until a host frame arrives.
- R2: A start pulse is any run of one or more low clocks seen in idle. The start frame ends at the first clock the wire is seen high, and a start pulse of any width is accepted.
- R3: Slot n (n from 0 to NUM_SLOTS-1) takes three clocks, counted from the clock after the start frame ends. The block drives the wire low in the sample clock, high in the recovery clock and releases it in the turn-around clock. Recovery and turn-around always follow.
- R4: The request level and the slot number are captured on the clock that ends the start frame. A later change has no effect until the next frame, and the slot is driven in every frame whose captured request is high.
- R5: No slot is driven in a frame whose captured request is low.
- R6: Any number of high clocks may follow the last slot. A stop pulse of exactly 2 low clocks selects quiet mode, and a pulse of any other width selects continuous mode.
- R7: In quiet mode, with the wire idle and the request high, the block drives the wire low for exactly one clock and then releases it. It then follows the start pulse that the host extends.
- R8: In quiet mode, with no request, the block leaves an idle wire released.
- R9: If the request falls after a self-started pulse but before the start frame ends, no slot is driven and the frame is still tracked to its stop. Later frames behave normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Interrupt request level from the register logic |
| irq_num | input | $clog2(NUM_SLOTS) | Slot number to report |
| sirq_in | input | 1 | Sampled level of the serial interrupt wire |
| sirq_oe | output | 1 | Drive enable for the wire pad |
| sirq_drv | output | 1 | Value driven when `sirq_oe` is high |

## Verification
The hardest case to reach from the ports is a spurious self-started frame. Reaching it needs three things:
- The block must already be in quiet mode.
- It must have pulsed the wire on its own.
- The request must fall in the short window before the host releases the start pulse.

The bench first establishes quiet mode by ending a frame with a two-clock stop pulse. It then raises the request so that the block pulses, and drops the request while the host is still holding the start pulse low. It checks that every slot stays released, and then confirms that a later host frame still reports normally. A slot-number change placed right after the capture clock, and a request held high across a reset in quiet mode, cover the other narrow windows.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KICK,
        ST_START,
        ST_SLOTS,
        ST_WAIT_STOP,
        ST_STOP
    } sirq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE  = 2'd0,
        PH_RECOVER = 2'd1,
        PH_TURN    = 2'd2
    } slot_phase_e;

endpackage

// File: rtl/sirq_slot_timer.sv
`timescale 1ns/1ps
module sirq_slot_timer
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_W     = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    output slot_phase_e      phase,
    output logic [NUM_W-1:0] slot,
    output logic             last_turn
);

    localparam logic [NUM_W-1:0] LAST_SLOT = NUM_W'(NUM_SLOTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_SAMPLE;
            slot  <= '0;
        end else if (load) begin
            phase <= PH_SAMPLE;
            slot  <= '0;
        end else if (run) begin
            unique case (phase)
                PH_SAMPLE:  phase <= PH_RECOVER;
                PH_RECOVER: phase <= PH_TURN;
                default: begin
                    phase <= PH_SAMPLE;
                    slot  <= slot + 1'b1;
                end
            endcase
        end
    end

    assign last_turn = (phase == PH_TURN) && (slot == LAST_SLOT);

    // R3
    slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && phase == PH_TURN && !last_turn) |=> (phase == PH_SAMPLE && slot != $past(slot)));

endmodule

// File: rtl/sirq_stop_decoder.sv
`timescale 1ns/1ps
module sirq_stop_decoder #(
    parameter int QUIET_WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic begin_i,
    input  logic low_i,
    input  logic end_i,
    output logic quiet_o
);

    localparam int CW = $clog2(QUIET_WIDTH + 2);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            quiet_o <= 1'b0;
        end else begin
            if (begin_i) begin
                low_cnt <= CW'(1);
            end else if (low_i && low_cnt != '1) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (end_i) begin
                quiet_o <= (low_cnt == CW'(QUIET_WIDTH));
            end
        end
    end

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_i |=> $stable(quiet_o));

endmodule

// File: rtl/sirq_frame_gen.sv
`timescale 1ns/1ps
module sirq_frame_gen
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS        = 16,
    parameter int QUIET_STOP_WIDTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         irq_req,
    input  logic [$clog2(NUM_SLOTS)-1:0] irq_num,
    input  logic                         sirq_in,
    output logic                         sirq_oe,
    output logic                         sirq_drv
);

    localparam int NUM_W = $clog2(NUM_SLOTS);

    sirq_state_e      state, state_nx;
    slot_phase_e      phase;
    logic [NUM_W-1:0] slot;
    logic [NUM_W-1:0] num_q;
    logic             req_q;
    logic             last_turn;
    logic             quiet;
    logic             frame_go;
    logic             slot_hit;

    assign frame_go = (state == ST_START) && sirq_in;
    assign slot_hit = req_q && (slot == num_q);

    sirq_slot_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_W     (NUM_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_go),
        .run       (state == ST_SLOTS),
        .phase     (phase),
        .slot      (slot),
        .last_turn (last_turn)
    );

    sirq_stop_decoder #(
        .QUIET_WIDTH (QUIET_STOP_WIDTH)
    ) u_stop (
        .clk     (clk),
        .rst_n   (rst_n),
        .begin_i ((state == ST_WAIT_STOP) && !sirq_in),
        .low_i   ((state == ST_STOP) && !sirq_in),
        .end_i   ((state == ST_STOP) && sirq_in),
        .quiet_o (quiet)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!sirq_in)              state_nx = ST_START;
                else if (quiet && irq_req) state_nx = ST_KICK;
            end
            ST_KICK:      state_nx = ST_START;
            ST_START:     if (sirq_in)   state_nx = ST_SLOTS;
            ST_SLOTS:     if (last_turn) state_nx = ST_WAIT_STOP;
            ST_WAIT_STOP: if (!sirq_in)  state_nx = ST_STOP;
            ST_STOP:      if (sirq_in)   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            num_q <= '0;
        end else if (frame_go) begin
            req_q <= irq_req;
            num_q <= irq_num;
        end
    end

    always_comb begin
        sirq_oe  = 1'b0;
        sirq_drv = 1'b1;
        unique case (state)
            ST_KICK: begin
                sirq_oe  = 1'b1;
                sirq_drv = 1'b0;
            end
            ST_SLOTS: begin
                if (slot_hit && phase != PH_TURN) begin
                    sirq_oe  = 1'b1;
                    sirq_drv = (phase == PH_RECOVER);
                end
            end
            default: ;
        endcase
    end

    // R3
    recovery_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOTS && sirq_oe && !sirq_drv) |=> (sirq_oe && sirq_drv));

    // R7
    kick_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KICK) |=> !sirq_oe);

    // R4
    num_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOTS && $past(state) == ST_SLOTS) |-> $stable(num_q));

    // R5
    no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOTS && !req_q) |-> !sirq_oe);

endmodule

// File: tb/sirq_frame_gen_tb.sv
`timescale 1ns/1ps
module sirq_frame_gen_tb;

    localparam int NS = 16;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_req = 1'b0;
    logic          host_low = 1'b0;
    logic [NW-1:0] irq_num = '0;
    logic          sirq_oe, sirq_drv, sirq_in;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign sirq_in = !(host_low || (sirq_oe && !sirq_drv));

    sirq_frame_gen #(.NUM_SLOTS(NS), .QUIET_STOP_WIDTH(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .irq_num  (irq_num),
        .sirq_in  (sirq_in),
        .sirq_oe  (sirq_oe),
        .sirq_drv (sirq_drv)
    );

    // One call per clock: compare this clock's outputs, then set the host drive for the next edge.
    task automatic cyc(input bit hl, input bit e_oe, input bit e_drv, input string tag);
        @(negedge clk);
        n_vec++;
        if (sirq_oe !== e_oe || (e_oe && sirq_drv !== e_drv)) begin
            n_bad++;
            $display("FAIL %s: oe/drv=%b/%b expected %b/%b at %0t",
                     tag, sirq_oe, sirq_drv, e_oe, e_drv, $time);
        end
        host_low = hl;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, tag);
    endtask

    task automatic frame_body(input int low_more, input bit drop_req, input bit chg,
                              input logic [NW-1:0] new_num, input int gap,
                              input int stop_len, input string tag);
        bit            lr;
        logic [NW-1:0] ln;
        for (int i = 0; i < low_more; i++) cyc(1, 0, 0, "R2 start held");
        if (drop_req) irq_req = 1'b0;
        cyc(0, 0, 0, "R2 start release");
        lr = irq_req;
        ln = irq_num;
        for (int k = 0; k < NS; k++) begin
            bit hit;
            hit = lr && (k == int'(ln));
            cyc(0, hit, 0, tag);
            if (chg && k == 0) irq_num = new_num;
            cyc(0, hit, 1, tag);
            cyc(0, 0, 0, tag);
        end
        irq_req = 1'b0;
        for (int i = 0; i < gap; i++) cyc(0, 0, 0, "R6 gap");
        for (int i = 0; i < stop_len; i++) cyc(1, 0, 0, "R6 stop");
        cyc(0, 0, 0, "R6 stop release");
    endtask

    task automatic host_frame(input int start_len, input bit chg, input logic [NW-1:0] new_num,
                              input int gap, input int stop_len, input string tag);
        cyc(1, 0, 0, "R2 start");
        frame_body(start_len - 1, 1'b0, chg, new_num, gap, stop_len, tag);
    endtask

    // The request was raised after the previous call: the block pulses in this clock.
    task automatic kick_frame(input int ext, input bit drop_req, input int stop_len, input string tag);
        cyc(1, 1, 0, "R7 self start");
        frame_body(ext, drop_req, 1'b0, '0, 0, stop_len, tag);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1: run not finished, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        irq_req = 1'b1;
        idle(3, "R1 in reset");
        rst_n = 1'b1;
        idle(6, "R1 continuous no self start");

        irq_req = 1'b1; irq_num = 4'd3;
        host_frame(1, 0, '0, 0, 3, "R3 slot 3 min start");

        irq_req = 1'b1; irq_num = 4'd0;
        host_frame(6, 1, 4'd9, 4, 3, "R4 late number change");

        irq_req = 1'b1; irq_num = 4'd9;
        host_frame(2, 0, '0, 0, 3, "R4 repeat frame");

        irq_req = 1'b0; irq_num = 4'd7;
        host_frame(3, 0, '0, 1, 4, "R5 no request");
        irq_req = 1'b1;
        idle(5, "R6 stop width 4 continuous");
        irq_req = 1'b0;

        irq_req = 1'b1; irq_num = 4'd15;
        host_frame(4, 0, '0, 2, 2, "R3 last slot");
        idle(5, "R8 quiet no request");

        irq_num = 4'd11; irq_req = 1'b1;
        kick_frame(3, 0, 2, "R7 self started slot 11");
        idle(2, "R8 quiet after frame");

        irq_num = 4'd2; irq_req = 1'b1;
        kick_frame(2, 1, 3, "R9 spurious no slot");
        idle(2, "R9 idle after spurious");

        irq_req = 1'b1; irq_num = 4'd2;
        host_frame(2, 0, '0, 0, 2, "R9 normal after spurious");
        idle(1, "R8 quiet idle");

        rst_n = 1'b0; irq_req = 1'b1;
        idle(2, "R1 reset in quiet");
        rst_n = 1'b1;
        idle(6, "R1 continuous after reset");

        irq_num = 4'd4;
        host_frame(3, 0, '0, 3, 3, "R3 slot 4 after reset");
        idle(3, "R1 final idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule